// File: doc/BRIEF.md
# Two-to-one symmetric compensation decimator

This block halves the sample rate of a signed stream while applying a fixed six-tap droop-compensation response. It is written in polyphase form. Each incoming pair of samples is split into a first sample and a second sample. The first sample waits in a holding register. When the second sample arrives, both samples and the stored history of earlier pairs are combined into one output, so all arithmetic runs once per pair.

The taps are symmetric. Each pair of mirrored samples is therefore added before it is scaled, which needs three constant products instead of six. Each product is built from a few shifted copies of the pre-added value, combined by addition and subtraction, with no general multiplier. Full precision is kept through the sum. A single round-half-up step then produces an output one bit wider than the input. The block sits after a comb-integrator stage that runs at the higher rate, and it is fed through a simple valid strobe.

Top module: `comp_decim2`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears the holding register, both history lines, the pair phase, `dout` and `dout_valid`. After reset, the next accepted sample is treated as the first of a pair, even if reset arrived in the middle of a pair.
- R2: `dout_valid` is high for exactly one cycle, in the cycle after every second accepted sample (`din_valid` high at a rising edge), counting from reset. It is low in every other cycle. Two pulses are never adjacent.
- R3: Write x[n] for the most recent accepted sample and x[n-k] for the sample accepted k samples earlier. The output for that sample is y = 3762·(x[n]+x[n-5]) + 10820·(x[n-1]+x[n-4]) + 7638·(x[n-2]+x[n-3]). These integers are the taps in Q1.15.
- R4: `dout` equals floor((y + 16384) / 32768), that is, y rounded once at bit 15 with halves rounded up. For example, an output whose only term is 10820·(−1) gives 0, and one whose only term is 10820·(−2) gives −1.
- R5: In any cycle without an output pulse, `dout` keeps the value of the last output. Cycles with `din_valid` low change no state.
- R6: The first outputs after reset treat every sample from before reset as zero.
- R7: Inputs at full positive or full negative scale, in any mix, give the exact value of R4 with no wrap. The output is IN_W+1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din_valid | input | 1 | Marks `din` as an accepted sample |
| din | input | IN_W | Signed input sample |
| dout_valid | output | 1 | One-cycle strobe for a new output |
| dout | output | IN_W+1 | Signed rounded output sample |

## Verification
Two things can happen in the same cycle: the block emits the output of one pair, and it accepts the first sample of the next pair into the holding register while the history lines have just shifted. An unbroken run of valid samples forces this overlap on every pair. Bursts with random gaps separate the two events, and a reset in the middle of a pair tests how the pair phase restarts. Each output pulse is compared against an independent model of the six-tap sum and its rounding. Each idle cycle is checked for a missing pulse and for a held output value.

// File: rtl/comp_decim2.sv
module comp_decim2 #(
  parameter int IN_W = 18,
  localparam int OUT_W = IN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    din_valid,
  input  logic signed [IN_W-1:0]  din,
  output logic                    dout_valid,
  output logic signed [OUT_W-1:0] dout
);

  localparam int FRAC  = 15;
  localparam int ACC_W = IN_W + FRAC + 3;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);

  logic                   phase;
  logic signed [IN_W-1:0] held, a1, a2, b1, b2;

  logic signed [IN_W:0]    s0, s1, s2;
  logic signed [ACC_W-1:0] e0, e1, e2, p0, p1, p2, acc;
  logic        [ACC_W-1:0] rnd;

  assign s0 = {din[IN_W-1], din}   + {a2[IN_W-1], a2};
  assign s1 = {held[IN_W-1], held} + {b2[IN_W-1], b2};
  assign s2 = {b1[IN_W-1], b1}     + {a1[IN_W-1], a1};

  assign e0 = ACC_W'(s0);
  assign e1 = ACC_W'(s1);
  assign e2 = ACC_W'(s2);

  assign p0 = (e0 <<< 12) - (e0 <<< 8) - (e0 <<< 6) - (e0 <<< 4) + (e0 <<< 1);
  assign p1 = (e1 <<< 13) + (e1 <<< 11) + (e1 <<< 9) + (e1 <<< 6) + (e1 <<< 2);
  assign p2 = (e2 <<< 13) - (e2 <<< 9) - (e2 <<< 5) - (e2 <<< 3) - (e2 <<< 1);

  assign acc = p0 + p1 + p2;
  assign rnd = acc + HALF;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= 1'b0;
      held       <= '0;
      a1         <= '0;
      a2         <= '0;
      b1         <= '0;
      b2         <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= 1'b0;
      if (din_valid) begin
        phase <= ~phase;
        if (!phase) begin
          held <= din;
        end else begin
          a1         <= held;
          a2         <= a1;
          b1         <= din;
          b2         <= b1;
          dout       <= rnd[FRAC+OUT_W-1:FRAC];
          dout_valid <= 1'b1;
        end
      end
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dout_valid && dout == '0));

  p_pulse_needs_input_r2: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> $past(din_valid));

  p_pulse_isolated_r2: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> !dout_valid);

  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    !dout_valid |-> $stable(dout));

endmodule

// File: tb/comp_decim2_bench.sv
module comp_decim2_bench;
  localparam int IN_W  = 18;
  localparam int OUT_W = IN_W + 1;
  localparam longint MAXV = (longint'(1) <<< (IN_W - 1)) - 1;
  localparam longint MINV = -(longint'(1) <<< (IN_W - 1));

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst = 1'b1;
  logic                    din_valid = 1'b0;
  logic signed [IN_W-1:0]  din = '0;
  logic                    dout_valid;
  logic signed [OUT_W-1:0] dout;

  comp_decim2 #(.IN_W(IN_W)) u_comp_decim2 (
    .clk(clk), .rst(rst), .din_valid(din_valid), .din(din),
    .dout_valid(dout_valid), .dout(dout)
  );

  int     checks = 0, failures = 0;
  bit     done = 1'b0;
  longint hist[6];
  bit     ph, pend;
  longint expv, last;
  string  req;

  function automatic longint model_out();
    longint acc;
    acc = 3762 * (hist[0] + hist[5]) + 10820 * (hist[1] + hist[4]) + 7638 * (hist[2] + hist[3]);
    return (acc + 16384) >>> 15;
  endfunction

  task automatic chk(string r, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, got, exp);
    end
  endtask

  task automatic step(bit v, longint x);
    @(negedge clk);
    if (pend) begin
      chk(req, "pulse", longint'(dout_valid), 1);
      chk(req, "data", longint'(dout), expv);
      last = expv;
    end else begin
      chk("R2", "no pulse", longint'(dout_valid), 0);
      chk("R5", "held output", longint'(dout), last);
    end
    din_valid = v;
    din = x[IN_W-1:0];
    pend = 1'b0;
    if (v) begin
      for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      if (ph) begin
        expv = model_out();
        pend = 1'b1;
      end
      ph = ~ph;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "valid in reset", longint'(dout_valid), 0);
    chk("R1", "data in reset", longint'(dout), 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) hist[i] = 0;
    ph = 1'b0;
    pend = 1'b0;
    last = 0;
  endtask

  function automatic longint rnd_sample();
    return longint'(int'($urandom()) >>> (32 - IN_W));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    do_reset();

    req = "R6";
    step(1, 1000); step(1, 2000); step(1, -3000); step(1, 500); step(0, 0);

    do_reset();
    req = "R3";
    step(1, 65536);
    for (int i = 0; i < 7; i++) step(1, 0);
    step(1, 0); step(1, 131071); step(1, -7);
    for (int i = 0; i < 6; i++) step(1, 0);
    step(0, 0);

    do_reset();
    req = "R4";
    step(1, -1); step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    step(1, -2); step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    step(1, 1);  step(1, 1); step(1, 3); step(1, -3); step(1, 0); step(1, 0);
    step(0, 0);

    do_reset();
    req = "R7";
    for (int i = 0; i < 8; i++) step(1, MAXV);
    for (int i = 0; i < 8; i++) step(1, MINV);
    for (int i = 0; i < 8; i++) step(1, (i % 2 == 0) ? MAXV : MINV);
    for (int i = 0; i < 8; i++) step(1, (i % 4 < 2) ? MINV : MAXV);
    step(0, 0);

    req = "R2";
    for (int i = 0; i < 400; i++) step(1, rnd_sample());

    req = "R5";
    for (int i = 0; i < 600; i++) step(($urandom() % 3) == 0, rnd_sample());

    req = "R1";
    step(1, 4444); step(0, 0);
    do_reset();
    step(1, 100); step(1, 200); step(1, 300); step(1, 400); step(0, 0); step(0, 0);

    req = "R3";
    for (int i = 0; i < 200; i++) step(($urandom() % 2) == 0, rnd_sample());
    step(0, 0); step(0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule